// File: doc/BRIEF.md
# Reset Time-out Sequencer

This block keeps a processor core in reset after a reset event until the start-up delays that event calls for have elapsed. Two stages are chained in a fixed order. The first is a power-up timer that counts ticks of a slow, always-running timebase. The second is an oscillator start-up counter that counts clock cycles, but only while a clock-valid input is high. Whether each stage runs depends on the oscillator mode, the power-up-timer disable bit and the kind of event: power-on, brown-out, or wake from sleep.

The power-on pulse is the asynchronous reset of the block. The time-out is measured from the release of that pulse, not from the external reset pin. If the pin is held low past the end of the time-out, releasing it lets the core go one cycle later with no added delay. A brown-out request restarts the whole sequence. A wake from sleep runs only the oscillator stage, and only in crystal modes.

Top module: `reset_timeout_seq`

## Requirements
- R1: While `por_i` is high, `core_rst_o` and `busy_o` are both 1.
- R2: Take edge 1 as the first clock edge after `por_i` falls. With a crystal mode (`osc_mode_i` values 0, 1, 2), `pwrt_dis_i`=0, and `slow_tick_i` and `clk_ok_i` held high, `busy_o` is first seen low after edge 1+PWRT_TICKS+OST_CYCLES.
- R3: `pwrt_dis_i`=1 skips the power-up timer. The release edge is then 1+OST_CYCLES in crystal modes and 1 in the other modes.
- R4: With `osc_mode_i` values 3 to 7 there is no oscillator stage. The release edge is 1+PWRT_TICKS with the timer enabled, and 1 with it disabled.
- R5: The power-up timer advances only on edges where `slow_tick_i` is 1. If ticks arrive only on even edges, the release edge is 2·PWRT_TICKS+OST_CYCLES in crystal modes and 2·PWRT_TICKS otherwise.
- R6: The oscillator stage counts only edges where `clk_ok_i` is 1. Each edge inside the stage where `clk_ok_i` is 0 delays the release by one edge.
- R7: `bor_i` high at edge X restarts the sequence, using the same stage selection as power-on. `busy_o` then falls at edge X+1+(the stage lengths).
- R8: `wake_i` at edge X while the sequence is done starts only the oscillator stage in crystal modes, releasing at X+OST_CYCLES. It has no effect in other modes, and no effect while a stage is running.
- R9: `core_rst_o` is a register loaded with (`mclr_n_i`==0 OR a stage is still due). The pin does not change the stage timing. Releasing the pin after the time-out drops `core_rst_o` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| por_i | input | 1 | Power-on pulse, active high, asynchronous |
| bor_i | input | 1 | Brown-out reset request, synchronous |
| mclr_n_i | input | 1 | External reset pin, active low |
| wake_i | input | 1 | Wake-from-sleep event |
| osc_mode_i | input | 3 | Oscillator mode; 0..2 crystal, 3..7 non-crystal |
| pwrt_dis_i | input | 1 | 1 disables the power-up timer |
| slow_tick_i | input | 1 | Slow timebase tick, one per timer step |
| clk_ok_i | input | 1 | Oscillator clock is valid |
| core_rst_o | output | 1 | Core reset, registered |
| busy_o | output | 1 | A time-out stage is pending or running |

## Verification
Every result is due a known number of edges after its stimulus. The release edge is counted from the falling edge of the power-on pulse, from the edge where brown-out or wake is sampled, or from the edge where the pin rises, and the expected count is worked out arithmetically from the stage lengths and the tick and gating patterns. The bench drives inputs and samples outputs at falling clock edges and records the first edge index at which `busy_o` reads low. That index must equal the computed one exactly, so a release that comes one edge early or one edge late is reported. Pin effects on `core_rst_o` are sampled one edge after the pin changes.

// File: rtl/rtseq_pkg.sv
package rtseq_pkg;

    typedef enum logic [1:0] {
        ST_LAUNCH = 2'd0,
        ST_PWRT   = 2'd1,
        ST_OST    = 2'd2,
        ST_RUN    = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       core_rst;
    } seq_regs_t;

    // Crystal-type modes occupy the lowest three codes.
    function automatic logic is_xtal(input logic [2:0] mode);
        return (mode < 3'd3);
    endfunction

endpackage

// File: rtl/rtseq_stage_ctr.sv
module rtseq_stage_ctr #(
    parameter int unsigned LENGTH = 16
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic run_i,
    input  logic step_i,
    output logic expire_o
);
    localparam int unsigned CW = (LENGTH > 1) ? $clog2(LENGTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(LENGTH - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_regs_t;

    ctr_regs_t ctr_d, ctr_q;
    logic      at_last;

    always_comb begin
        ctr_d    = ctr_q;
        at_last  = (ctr_q.cnt == LAST);
        expire_o = run_i && step_i && at_last;
        if (!run_i) begin
            ctr_d.cnt = '0;
        end else if (step_i) begin
            ctr_d.cnt = at_last ? '0 : ctr_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    // R5 / R6: the count never passes the stage length
    a_r5_count_bounded: assert property (@(posedge clk_i) disable iff (por_i)
        ctr_q.cnt <= LAST);

    // R5 / R6: without a step the count holds (or clears when the stage ends)
    a_r6_hold_without_step: assert property (@(posedge clk_i) disable iff (por_i)
        (run_i && !step_i) |=> (ctr_q.cnt == $past(ctr_q.cnt)) || (ctr_q.cnt == '0));

endmodule

// File: rtl/reset_timeout_seq.sv
module reset_timeout_seq
    import rtseq_pkg::*;
#(
    parameter int unsigned PWRT_TICKS = 64,
    parameter int unsigned OST_CYCLES = 1024
) (
    input  logic       clk_i,
    input  logic       por_i,
    input  logic       bor_i,
    input  logic       mclr_n_i,
    input  logic       wake_i,
    input  logic [2:0] osc_mode_i,
    input  logic       pwrt_dis_i,
    input  logic       slow_tick_i,
    input  logic       clk_ok_i,
    output logic       core_rst_o,
    output logic       busy_o
);
    seq_regs_t seq_d, seq_q;
    logic      xtal;
    logic      pwrt_run, ost_run;
    logic      pwrt_exp, ost_exp;

    assign xtal     = is_xtal(osc_mode_i);
    assign pwrt_run = (seq_q.state == ST_PWRT);
    assign ost_run  = (seq_q.state == ST_OST);

    rtseq_stage_ctr #(.LENGTH(PWRT_TICKS)) u_pwrt_ctr (
        .clk_i   (clk_i),
        .por_i   (por_i),
        .run_i   (pwrt_run),
        .step_i  (slow_tick_i),
        .expire_o(pwrt_exp)
    );

    rtseq_stage_ctr #(.LENGTH(OST_CYCLES)) u_ost_ctr (
        .clk_i   (clk_i),
        .por_i   (por_i),
        .run_i   (ost_run),
        .step_i  (clk_ok_i),
        .expire_o(ost_exp)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_LAUNCH: begin
                if (!pwrt_dis_i)  seq_d.state = ST_PWRT;
                else if (xtal)    seq_d.state = ST_OST;
                else              seq_d.state = ST_RUN;
            end
            ST_PWRT: begin
                if (pwrt_exp)     seq_d.state = xtal ? ST_OST : ST_RUN;
            end
            ST_OST: begin
                if (ost_exp)      seq_d.state = ST_RUN;
            end
            ST_RUN: begin
                if (wake_i && xtal) seq_d.state = ST_OST;
            end
            default:              seq_d.state = ST_LAUNCH;
        endcase
        if (bor_i) begin
            seq_d.state = ST_LAUNCH;
        end
        seq_d.core_rst = !mclr_n_i || (seq_d.state != ST_RUN);
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            seq_q.state    <= ST_LAUNCH;
            seq_q.core_rst <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign core_rst_o = seq_q.core_rst;
    assign busy_o     = (seq_q.state != ST_RUN);

    // R9: a pending stage always keeps the core in reset
    a_r9_busy_holds_core: assert property (@(posedge clk_i) disable iff (por_i)
        busy_o |-> core_rst_o);

    // R9: a low pin holds the core on the following cycle
    a_r9_pin_holds_core: assert property (@(posedge clk_i) disable iff (por_i)
        !mclr_n_i |=> core_rst_o);

    // R7: brown-out restarts the sequence
    a_r7_bor_restarts: assert property (@(posedge clk_i) disable iff (por_i)
        bor_i |=> busy_o && core_rst_o && (seq_q.state == ST_LAUNCH));

    // R3: a disabled power-up timer is never entered from launch
    a_r3_timer_bypassed: assert property (@(posedge clk_i) disable iff (por_i)
        (seq_q.state == ST_LAUNCH && pwrt_dis_i && !bor_i) |=> seq_q.state != ST_PWRT);

    // R6: start-up stage waits while the clock is not valid
    a_r6_ost_waits: assert property (@(posedge clk_i) disable iff (por_i)
        (ost_run && !clk_ok_i && !bor_i) |=> seq_q.state == ST_OST);

    // R8: wake in a non-crystal mode keeps the core running
    a_r8_wake_no_delay: assert property (@(posedge clk_i) disable iff (por_i)
        (!busy_o && wake_i && !xtal && !bor_i) |=> !busy_o);

endmodule

// File: tb/reset_timeout_seq_test.sv
module reset_timeout_seq_test;

    localparam int PT = 16;
    localparam int OC = 1024;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       bor = 1'b0;
    logic       mclr_n = 1'b1;
    logic       wake = 1'b0;
    logic [2:0] osc_mode = 3'd0;
    logic       pwrt_dis = 1'b0;
    logic       slow_tick = 1'b1;
    logic       clk_ok = 1'b1;
    logic       core_rst_o;
    logic       busy_o;

    int n_cmp = 0;
    int n_bad = 0;
    int ecount = 0;
    int e0 = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) ecount <= ecount + 1;

    reset_timeout_seq #(.PWRT_TICKS(PT), .OST_CYCLES(OC)) uut (
        .clk_i      (clk),
        .por_i      (por),
        .bor_i      (bor),
        .mclr_n_i   (mclr_n),
        .wake_i     (wake),
        .osc_mode_i (osc_mode),
        .pwrt_dis_i (pwrt_dis),
        .slow_tick_i(slow_tick),
        .clk_ok_i   (clk_ok),
        .core_rst_o (core_rst_o),
        .busy_o     (busy_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic power_on(input int mode, input int dis);
        @(negedge clk);
        por      = 1'b1;
        osc_mode = 3'(mode);
        pwrt_dis = dis[0];
        repeat (2) @(negedge clk);
        por = 1'b0;
    endtask

    // Finds the first edge index (relative to now) after which busy_o reads low.
    task automatic measure(input int exp_k, input int tick_even, input int gl, input int gh,
                           input int bor_at, input int wake_at, input string tag);
        int k = 0;
        int got = -1;
        bit seen = 1'b0;
        e0 = ecount;
        while (!seen && k <= exp_k + 20) begin
            slow_tick = (tick_even == 0) || (((k + 1) % 2) == 0);
            clk_ok    = !((k + 1) >= gl && (k + 1) <= gh);
            bor       = ((k + 1) == bor_at);
            wake      = ((k + 1) == wake_at);
            @(negedge clk);
            k = ecount - e0;
            if (!busy_o) begin
                seen = 1'b1;
                got  = k;
            end
        end
        slow_tick = 1'b1;
        clk_ok    = 1'b1;
        bor       = 1'b0;
        wake      = 1'b0;
        check(got == exp_k, tag, got, exp_k);
    endtask

    initial begin
        #(150000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check(core_rst_o == 1'b1, "R1 core_rst during power-on", int'(core_rst_o), 1);
        check(busy_o == 1'b1, "R1 busy during power-on", int'(busy_o), 1);
        por = 1'b0;

        // R2, R3, R4: sweep of all modes and timer settings
        for (int m = 0; m < 8; m++) begin
            for (int d = 0; d < 2; d++) begin
                int expv;
                string req;
                expv = 1 + ((d == 0) ? PT : 0) + ((m < 3) ? OC : 0);
                req  = (d == 1) ? "R3" : ((m < 3) ? "R2" : "R4");
                power_on(m, d);
                measure(expv, 0, 0, 0, 0, 0, $sformatf("%s release mode %0d dis %0d", req, m, d));
                check(core_rst_o == 1'b0, $sformatf("R9 core_rst after release mode %0d", m),
                      int'(core_rst_o), 0);
            end
        end

        // R5: ticks on even edges only
        power_on(1, 0);
        measure(2 * PT + OC, 1, 0, 0, 0, 0, "R5 sparse ticks crystal");
        power_on(3, 0);
        measure(2 * PT, 1, 0, 0, 0, 0, "R5 sparse ticks external clock");

        // R6: 50 invalid-clock edges inside the start-up stage
        power_on(2, 1);
        measure(1 + OC + 50, 0, 100, 149, 0, 0, "R6 gated start-up");

        // R7: brown-out restarts during start-up stage and during timer
        power_on(0, 0);
        measure(301 + PT + OC, 0, 0, 0, 300, 0, "R7 restart in start-up stage");
        power_on(5, 0);
        measure(6 + PT, 0, 0, 0, 5, 0, "R7 restart in timer stage");

        // R8: wake ignored while busy
        power_on(1, 0);
        measure(1 + PT + OC, 0, 0, 0, 0, 5, "R8 wake while busy ignored");

        // R8: wake from sleep in crystal mode
        power_on(1, 1);
        measure(1 + OC, 0, 0, 0, 0, 0, "R3 release before wake");
        measure(1 + OC, 0, 0, 0, 0, 1, "R8 wake crystal start-up only");

        // R8: wake in external-clock mode; R7 brown-out when done
        power_on(3, 1);
        measure(1, 0, 0, 0, 0, 0, "R4 zero time-out");
        measure(1, 0, 0, 0, 0, 1, "R8 wake no delay");
        measure(2, 0, 0, 0, 1, 0, "R7 brown-out zero-length sequence");

        // R9: pin held low past expiry
        @(negedge clk);
        mclr_n = 1'b0;
        power_on(0, 0);
        measure(1 + PT + OC, 0, 0, 0, 0, 0, "R9 timers run from power-on");
        check(core_rst_o == 1'b1, "R9 pin still holds core", int'(core_rst_o), 1);
        mclr_n = 1'b1;
        @(negedge clk);
        check(core_rst_o == 1'b0, "R9 release one edge after pin", int'(core_rst_o), 0);
        mclr_n = 1'b0;
        @(negedge clk);
        check(core_rst_o == 1'b1, "R9 pin low asserts reset", int'(core_rst_o), 1);
        check(busy_o == 1'b0, "R9 pin starts no time-out", int'(busy_o), 0);
        mclr_n = 1'b1;
        @(negedge clk);
        check(core_rst_o == 1'b0, "R9 pin release immediate", int'(core_rst_o), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule